// File: doc/BRIEF.md
# Pointer Masking Address Transform

This block sits on the data-access path of a load/store unit. It receives the effective address of a memory access and, when pointer masking is in force, discards the top PMLEN bits of that address and rebuilds them. If translation is bare, the rebuilt field is zero. If a virtual translation mode is active, the rebuilt field is copies of the highest kept bit. PMLEN is either 7 or 16. When masking is not in force, the address goes through untouched.

The rebuilt address is the only one used after this point. The block checks it for misalignment and reports the matching fault cause. It hands the same address on to translation and to fault reporting. A parameter removes masking support altogether, and by default support is off. A second parameter selects an output register stage, which is on by default. With that stage, results appear one cycle after an input marked valid.

Top module: `ptrmask_unit`

## Requirements
- R1: With masking support built in, the address passes through unchanged when `mask_active` is low, or when `mask_mode` is 00 (off) or 01 (reserved, treated as off).
- R2: With masking support built in and `mask_active` high, `mask_mode` 10 masks the top 7 bits and `mask_mode` 11 masks the top 16 bits.
- R3: When masking applies and `xlat_bare` is 1, the masked top bits of the output address are zero and the lower bits equal the input.
- R4: When masking applies and `xlat_bare` is 0, the masked top bits of the output address all equal input bit XLEN-PMLEN-1, and the lower bits equal the input.
- R5: When the block is built with `PM_SUPPORT`=0, the output address always equals the input address, whatever the masking inputs are.
- R6: `acc_width` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An access is misaligned when any of the low log2(bytes) bits of the transformed address is set. A 1-byte access is never misaligned.
- R7: `acc_kind` codes are 0 load, 1 store, 2 AMO, 3 load-reserved, 4 store-conditional, 5 FP load, 6 FP store, and 7 reserved (behaves as load). AMO, LR and SC are always checked for alignment. The other kinds are checked only when `misal_ok` is 0.
- R8: `out_cause` is 00 when the access is aligned. It is 01 (load misaligned) for a misaligned load, LR or FP load, and 10 (store/AMO misaligned) for a misaligned store, SC, AMO or FP store. `out_misaligned` is 1 exactly when the cause is nonzero.
- R9: With the register stage, `out_valid` is high in the cycle after `in_valid` was high and low otherwise. After reset, `out_valid`, `out_addr`, `out_misaligned` and `out_cause` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input access is valid |
| eff_addr | input | XLEN | Effective address |
| mask_active | input | 1 | Pointer masking is in force for this privilege |
| mask_mode | input | 2 | 00 off, 01 reserved (off), 10 PMLEN=7, 11 PMLEN=16 |
| xlat_bare | input | 1 | 1 when address translation is bare |
| acc_width | input | 2 | Access size, log2 of the byte count |
| acc_kind | input | 3 | Access kind code |
| misal_ok | input | 1 | Platform supports misaligned ordinary accesses |
| out_valid | output | 1 | Result valid |
| out_addr | output | XLEN | Transformed address |
| out_misaligned | output | 1 | Misaligned access flag |
| out_cause | output | 2 | Fault cause code |

## Verification
Directed addresses with the guard bit at XLEN-PMLEN-1 set or clear, and with the masked field all ones or all zeros, separate zero extension from sign extension and 7-bit masking from 16-bit masking. Modes 00 and 01 with a dirty upper field show that the reserved code does not mask. A second instance built without support receives the same inputs, which shows that the build option overrides the runtime inputs. Random sweeps over kind, width, low address bits and `misal_ok` separate the strict atomic alignment rule from the platform-dependent rule, and separate load causes from store causes.

// File: rtl/ptrmask_pkg.sv
package ptrmask_pkg;

    typedef enum logic [2:0] {
        KIND_LOAD   = 3'd0,
        KIND_STORE  = 3'd1,
        KIND_AMO    = 3'd2,
        KIND_LR     = 3'd3,
        KIND_SC     = 3'd4,
        KIND_FLOAD  = 3'd5,
        KIND_FSTORE = 3'd6,
        KIND_RSVD   = 3'd7
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_LD_MIS = 2'b01,
        CAUSE_ST_MIS = 2'b10
    } cause_e;

    localparam int PMLEN_SHORT = 7;
    localparam int PMLEN_LONG  = 16;

endpackage

// File: rtl/ptrmask_xform.sv
module ptrmask_xform #(
    parameter int XLEN       = 64,
    parameter bit PM_SUPPORT = 1'b0
) (
    input  logic [XLEN-1:0] addr_i,
    input  logic            active_i,
    input  logic [1:0]      mode_i,
    input  logic            bare_i,
    output logic [XLEN-1:0] addr_o
);
    import ptrmask_pkg::*;

    localparam int NVAR = 2;

    logic [XLEN-1:0] ext [NVAR];
    logic            en;

    // One rebuilt address per supported mask length.
    for (genvar g = 0; g < NVAR; g++) begin : g_len
        localparam int PL   = (g == 0) ? PMLEN_SHORT : PMLEN_LONG;
        localparam int KEEP = XLEN - PL;
        always_comb begin
            if (bare_i) ext[g] = {{PL{1'b0}}, addr_i[KEEP-1:0]};
            else        ext[g] = {{PL{addr_i[KEEP-1]}}, addr_i[KEEP-1:0]};
        end
    end

    // Mode bit 1 turns masking on, mode bit 0 picks the long length.
    assign en = PM_SUPPORT && active_i && mode_i[1];

    always_comb begin
        if (en) addr_o = mode_i[0] ? ext[1] : ext[0];
        else    addr_o = addr_i;
    end

endmodule

// File: rtl/ptrmask_align.sv
module ptrmask_align (
    input  logic [2:0] addr_lo_i,
    input  logic [1:0] width_i,
    input  logic [2:0] kind_i,
    input  logic       misal_ok_i,
    output logic       misaligned_o,
    output logic [1:0] cause_o
);
    import ptrmask_pkg::*;

    logic [2:0] low_mask;
    logic       strict;
    logic       is_load;
    logic       off_bits;

    always_comb begin
        low_mask     = 3'((4'd1 << width_i) - 4'd1);
        off_bits     = |(addr_lo_i & low_mask);
        strict       = (kind_i == KIND_AMO) || (kind_i == KIND_LR) || (kind_i == KIND_SC);
        is_load      = (kind_i == KIND_LOAD) || (kind_i == KIND_LR) ||
                       (kind_i == KIND_FLOAD) || (kind_i == KIND_RSVD);
        misaligned_o = off_bits && (strict || !misal_ok_i);
        if (!misaligned_o) cause_o = CAUSE_NONE;
        else if (is_load)  cause_o = CAUSE_LD_MIS;
        else               cause_o = CAUSE_ST_MIS;
    end

endmodule

// File: rtl/ptrmask_unit.sv
module ptrmask_unit #(
    parameter int XLEN       = 64,
    parameter bit PM_SUPPORT = 1'b0,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] eff_addr,
    input  logic            mask_active,
    input  logic [1:0]      mask_mode,
    input  logic            xlat_bare,
    input  logic [1:0]      acc_width,
    input  logic [2:0]      acc_kind,
    input  logic            misal_ok,
    output logic            out_valid,
    output logic [XLEN-1:0] out_addr,
    output logic            out_misaligned,
    output logic [1:0]      out_cause
);

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] addr;
        logic            mis;
        logic [1:0]      cause;
    } res_t;

    logic [XLEN-1:0] xaddr;
    logic            mis;
    logic [1:0]      cause;
    res_t            res_d;
    res_t            res_q;

    ptrmask_xform #(
        .XLEN       (XLEN),
        .PM_SUPPORT (PM_SUPPORT)
    ) u_xform (
        .addr_i   (eff_addr),
        .active_i (mask_active),
        .mode_i   (mask_mode),
        .bare_i   (xlat_bare),
        .addr_o   (xaddr)
    );

    // Alignment is judged on the rebuilt address only.
    ptrmask_align u_align (
        .addr_lo_i    (xaddr[2:0]),
        .width_i      (acc_width),
        .kind_i       (acc_kind),
        .misal_ok_i   (misal_ok),
        .misaligned_o (mis),
        .cause_o      (cause)
    );

    if (REG_OUT) begin : g_reg
        always_comb begin
            res_d     = res_q;
            res_d.vld = in_valid;
            if (in_valid) begin
                res_d.addr  = xaddr;
                res_d.mis   = mis;
                res_d.cause = cause;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        always_comb begin
            res_d.vld   = in_valid;
            res_d.addr  = xaddr;
            res_d.mis   = mis;
            res_d.cause = cause;
        end
        assign res_q = res_d;
    end

    assign out_valid      = res_q.vld;
    assign out_addr       = res_q.addr;
    assign out_misaligned = res_q.mis;
    assign out_cause      = res_q.cause;

endmodule

// File: rtl/ptrmask_unit_chk.sv
module ptrmask_unit_chk #(
    parameter int XLEN       = 64,
    parameter bit PM_SUPPORT = 1'b0,
    parameter bit REG_OUT    = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] eff_addr,
    input logic            mask_active,
    input logic [1:0]      mask_mode,
    input logic            xlat_bare,
    input logic [1:0]      acc_width,
    input logic            out_valid,
    input logic [XLEN-1:0] out_addr,
    input logic            out_misaligned,
    input logic [1:0]      out_cause
);

    assert_cause_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_misaligned == (out_cause != 2'b00)) && (out_cause != 2'b11));

    if (REG_OUT) begin : g_seq
        assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));

        assert_byte_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && $past(acc_width == 2'd0) |-> !out_misaligned);

        assert_inactive_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && $past(!mask_active) |-> out_addr == $past(eff_addr));

        if (PM_SUPPORT) begin : g_pm
            assert_bare_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && $past(mask_active && mask_mode == 2'b11 && xlat_bare)
                |-> out_addr[XLEN-1 -: 16] == 16'h0);

            assert_virt_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && $past(mask_active && mask_mode == 2'b11 && !xlat_bare)
                |-> (out_addr[XLEN-1 -: 17] == 17'h0) || (&out_addr[XLEN-1 -: 17]));
        end else begin : g_nopm
            assert_no_support_R5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> out_addr == $past(eff_addr));
        end
    end

endmodule

bind ptrmask_unit ptrmask_unit_chk #(
    .XLEN       (XLEN),
    .PM_SUPPORT (PM_SUPPORT),
    .REG_OUT    (REG_OUT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .eff_addr       (eff_addr),
    .mask_active    (mask_active),
    .mask_mode      (mask_mode),
    .xlat_bare      (xlat_bare),
    .acc_width      (acc_width),
    .out_valid      (out_valid),
    .out_addr       (out_addr),
    .out_misaligned (out_misaligned),
    .out_cause      (out_cause)
);

// File: tb/ptrmask_unit_bench.sv
module ptrmask_unit_bench;

    localparam int XL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [XL-1:0] eff_addr = '0;
    logic          mask_active = 1'b0;
    logic [1:0]    mask_mode = 2'b00;
    logic          xlat_bare = 1'b0;
    logic [1:0]    acc_width = 2'd0;
    logic [2:0]    acc_kind = 3'd0;
    logic          misal_ok = 1'b0;

    logic          o_vld, n_vld;
    logic [XL-1:0] o_addr, n_addr;
    logic          o_mis, n_mis;
    logic [1:0]    o_cause, n_cause;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ptrmask_unit #(.XLEN(XL), .PM_SUPPORT(1'b1), .REG_OUT(1'b1)) u_ptrmask_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eff_addr(eff_addr),
        .mask_active(mask_active), .mask_mode(mask_mode), .xlat_bare(xlat_bare),
        .acc_width(acc_width), .acc_kind(acc_kind), .misal_ok(misal_ok),
        .out_valid(o_vld), .out_addr(o_addr), .out_misaligned(o_mis), .out_cause(o_cause));

    ptrmask_unit #(.XLEN(XL), .PM_SUPPORT(1'b0), .REG_OUT(1'b1)) u_ptrmask_unit_off (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eff_addr(eff_addr),
        .mask_active(mask_active), .mask_mode(mask_mode), .xlat_bare(xlat_bare),
        .acc_width(acc_width), .acc_kind(acc_kind), .misal_ok(misal_ok),
        .out_valid(n_vld), .out_addr(n_addr), .out_misaligned(n_mis), .out_cause(n_cause));

    function automatic logic [XL-1:0] ref_addr(logic [XL-1:0] a, logic act,
                                               logic [1:0] md, logic bare);
        int pl;
        logic [XL-1:0] keep_m;
        if (!(act && md[1])) return a;
        pl     = md[0] ? 16 : 7;
        keep_m = (64'h1 << (XL - pl)) - 64'h1;
        if (bare || !a[XL-1-pl]) return a & keep_m;
        return a | ~keep_m;
    endfunction

    function automatic logic ref_mis(logic [XL-1:0] a, logic [1:0] w,
                                     logic [2:0] k, logic ok);
        logic strict;
        logic [XL-1:0] m;
        strict = (k == 3'd2) || (k == 3'd3) || (k == 3'd4);
        m = (64'h1 << w) - 64'h1;
        return ((a & m) != 0) && (strict || !ok);
    endfunction

    function automatic logic [1:0] ref_cause(logic mis, logic [2:0] k);
        if (!mis) return 2'b00;
        if (k == 3'd0 || k == 3'd3 || k == 3'd5 || k == 3'd7) return 2'b01;
        return 2'b10;
    endfunction

    task automatic check(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [XL-1:0] a, logic act, logic [1:0] md,
                       logic bare, logic [1:0] w, logic [2:0] k, logic ok);
        logic [XL-1:0] ea;
        logic em;
        @(negedge clk);
        in_valid = 1'b1; eff_addr = a; mask_active = act; mask_mode = md;
        xlat_bare = bare; acc_width = w; acc_kind = k; misal_ok = ok;
        ea = ref_addr(a, act, md, bare);
        em = ref_mis(ea, w, k, ok);
        @(negedge clk);
        check({req, " valid R9"}, 64'(o_vld), 64'd1);
        check({req, " addr"}, o_addr, ea);
        check({req, " mis R6 R7"}, 64'(o_mis), 64'(em));
        check({req, " cause R8"}, 64'(o_cause), 64'(ref_cause(em, k)));
        check({req, " nosupport addr R5"}, n_addr, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset valid", 64'(o_vld), 64'd0);
        check("R9 reset addr", o_addr, 64'd0);
        check("R9 reset cause", 64'(o_cause), 64'd0);
        rst_n = 1'b1;

        // R1 inactive / off / reserved mode
        run("R1 inactive", 64'hFFFF_8000_0000_1000, 1'b0, 2'b11, 1'b1, 2'd3, 3'd0, 1'b0);
        run("R1 mode00",   64'hABCD_0000_0000_0010, 1'b1, 2'b00, 1'b1, 2'd2, 3'd1, 1'b0);
        run("R1 mode01",   64'hABCD_0000_0000_0020, 1'b1, 2'b01, 1'b0, 2'd2, 3'd1, 1'b0);
        // R2 R3 bare, both lengths
        run("R2 R3 bare7",  64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 2'b10, 1'b1, 2'd3, 3'd0, 1'b0);
        run("R2 R3 bare16", 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 2'b11, 1'b1, 2'd3, 3'd0, 1'b0);
        // R2 R4 virtual, guard bit set and clear
        run("R4 virt7 neg",  64'h0100_0000_0000_0000, 1'b1, 2'b10, 1'b0, 2'd0, 3'd0, 1'b0);
        run("R4 virt7 pos",  64'hFE80_0000_0000_0004, 1'b1, 2'b10, 1'b0, 2'd2, 3'd1, 1'b0);
        run("R4 virt16 neg", 64'h0000_8000_0000_0000, 1'b1, 2'b11, 1'b0, 2'd1, 3'd2, 1'b0);
        run("R4 virt16 pos", 64'hFFFF_7FFF_0000_0000, 1'b1, 2'b11, 1'b0, 2'd1, 3'd2, 1'b0);
        // R6 R7 R8 alignment corners
        run("R7 amo strict",  64'h1002, 1'b0, 2'b00, 1'b0, 2'd2, 3'd2, 1'b1);
        run("R7 lr strict",   64'h1001, 1'b0, 2'b00, 1'b0, 2'd1, 3'd3, 1'b1);
        run("R7 sc strict",   64'h1004, 1'b0, 2'b00, 1'b0, 2'd3, 3'd4, 1'b1);
        run("R7 load ok",     64'h1003, 1'b0, 2'b00, 1'b0, 2'd3, 3'd0, 1'b1);
        run("R8 fload mis",   64'h1002, 1'b0, 2'b00, 1'b0, 2'd2, 3'd5, 1'b0);
        run("R8 fstore mis",  64'h1006, 1'b0, 2'b00, 1'b0, 2'd3, 3'd6, 1'b0);
        run("R6 byte",        64'h1007, 1'b0, 2'b00, 1'b0, 2'd0, 3'd4, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [XL-1:0] ra;
            ra = {$urandom, $urandom};
            run("R2 R3 R4 R7 random", ra, 1'($urandom), 2'($urandom), 1'($urandom),
                2'($urandom), 3'($urandom), 1'($urandom));
        end

        // R9 valid drops with no input
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 idle valid", 64'(o_vld), 64'd0);
        check("R9 idle nosupport valid", 64'(n_vld), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule